// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block is the programmed-I/O face of a read-only store of configuration items. Software writes a 16-bit key to choose an item; the key carries a bank flag that picks either a shared bank or an architecture-local bank, plus an index into that bank. Each key write rewinds a read cursor to the first byte of the chosen item. Data reads then stream the item's bytes out in order. A read of N bytes returns them packed most-significant first in the low N bytes of the result. Bytes past the item's end come back as zero.

A parameter selects one of two register layouts. In the combined layout, one port carries both functions: the access width decides whether it is a data read or a key write. In the split layout, a control register takes big-endian 2-byte key writes, and a data register at offset 0 takes reads of 1 to 8 bytes. The item table is built at elaboration from package functions, so the block has a fixed, known content for testing. Every request is answered one cycle later, with an error flag set for accesses the selected layout refuses.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selection is valid key 0x0000, the signature item, and the cursor is 0. Its four bytes are 0x51, 0x45, 0x4D, 0x55, so a first 4-byte read returns 0x51454D55. rsp_valid is low after reset.
- R2: Every accepted key write sets the cursor to 0, so selecting the same key again restarts at its first byte.
- R3: Key bit 14 picks the bank: 0 is shared, 1 is architecture-local. Bits 13:0 are the index. Bit 15 has no effect on which item is read.
- R4: A key whose index (bits 13:0) is at or above NUM_ENTRIES (8) makes the selection invalid. Every read, of any width, then returns zero.
- R5: A read of N bytes returns the item bytes from the cursor onward, the first in bits 8N-1:8N-8, and advances the cursor by the number of bytes delivered.
- R6: When fewer than N bytes remain, the delivered bytes stay at the top of the N-byte field and the low-order bytes are zero.
- R7: A read with the cursor at the item length, or on an item of length 0, returns zero and leaves the cursor unchanged.
- R8: In the combined layout (COMBINED=1), req_ctl and req_offset are ignored. A 1-byte read is a data read. A 1-byte write is accepted with no effect. A 2-byte write is a key write, with the key taken as req_wdata[15:0]. Every other width or direction gives rsp_err with no effect.
- R9: In the split layout (COMBINED=0), the control register (req_ctl=1) accepts only 2-byte writes, and the key is {req_wdata[7:0], req_wdata[15:8]}. The data register accepts reads of 1 to 8 bytes at offset 0. Data writes of 1 to 8 bytes at offset 0 are accepted with no effect. Anything else gives rsp_err with no effect.
- R10: Shared index 1 is the version item, 4 bytes long. Its first byte has bit 0 set, and bit 1 equal to DMA_AVAIL (default 0); the other three bytes are zero.
- R11: Any other item (bank b, index i) has length (i + 2 + 2b) mod (MAX_LEN+1), with MAX_LEN = 8. Byte j of that item is (128b + 16i + j) mod 256.
- R12: Every request cycle produces rsp_valid exactly one cycle later, and only then. Responses with rsp_err set, and responses to accepted writes, carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctl | input | 1 | Split layout: 1 addresses the control register |
| req_offset | input | 3 | Byte offset within the addressed register |
| req_size | input | 4 | Access width in bytes |
| req_wdata | input | 16 | Write data, byte lanes in ascending order |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 64 | Read result in the low req_size bytes |

## Verification
Two things can happen within a single access. One is the cursor advancing to the item end while zero padding fills the low bytes of the same read. The other is a key write that rewinds the cursor in the cycle straight after a read has moved it. Directed sequences cover both: reads wider than the bytes left, followed at once by a reselect of the same key. A bench model checks the packed value, and also checks that the next read starts from byte 0. Random mixes of key writes, reads of every width, ignored writes and refused accesses run on both layouts. The bench model follows the cursor on its own, so any missed or extra advance shows up in later data.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

    typedef enum logic [1:0] {
        ACC_NOP  = 2'd0,
        ACC_READ = 2'd1,
        ACC_SEL  = 2'd2,
        ACC_ERR  = 2'd3
    } acc_kind_e;

    // Length of item (bank, idx); two fixed shared items, the rest patterned.
    function automatic int item_len(input int bank, input int idx, input int max_len);
        if (bank == 0 && idx < 2) return 4;
        return (idx + 2 + 2 * bank) % (max_len + 1);
    endfunction

    // Byte j of item (bank, idx).
    function automatic logic [7:0] item_byte(input int bank, input int idx,
                                             input int j, input bit dma);
        logic [7:0] sig [4];
        sig = '{8'h51, 8'h45, 8'h4D, 8'h55};
        if (bank == 0 && idx == 0) return (j < 4) ? sig[j] : 8'h00;
        if (bank == 0 && idx == 1) return (j == 0) ? {6'b0, dma, 1'b1} : 8'h00;
        return 8'((128 * bank + 16 * idx + j) % 256);
    endfunction

endpackage

// File: rtl/cfg_item_rom.sv
module cfg_item_rom #(
    parameter int NUM_ENTRIES = 8,
    parameter int MAX_LEN     = 8,
    parameter int IDX_W       = 3,
    parameter int OFF_W       = 4,
    parameter bit DMA_AVAIL   = 1'b0
) (
    input  logic                   bank,
    input  logic [IDX_W-1:0]       idx,
    output logic [MAX_LEN*8-1:0]   item_bytes,
    output logic [OFF_W-1:0]       item_len
);
    localparam int NUM_BANKS = 2;

    function automatic logic [MAX_LEN*8-1:0] build_row(input int b, input int e);
        logic [MAX_LEN*8-1:0] row;
        row = '0;
        for (int j = 0; j < MAX_LEN; j++) begin
            row[j*8 +: 8] = cfg_item_pkg::item_byte(b, e, j, DMA_AVAIL);
        end
        return row;
    endfunction

    logic [MAX_LEN*8-1:0] row_tab [NUM_BANKS][NUM_ENTRIES];
    logic [OFF_W-1:0]     len_tab [NUM_BANKS][NUM_ENTRIES];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
            assign row_tab[b][e] = build_row(b, e);
            assign len_tab[b][e] = OFF_W'(cfg_item_pkg::item_len(b, e, MAX_LEN));
        end
    end

    always_comb begin
        item_bytes = '0;
        item_len   = '0;
        if (int'(idx) < NUM_ENTRIES) begin
            item_bytes = row_tab[bank][idx];
            item_len   = len_tab[bank][idx];
        end
    end
endmodule

// File: rtl/cfg_item_decode.sv
module cfg_item_decode #(
    parameter bit COMBINED = 1'b1,
    parameter int MAX_ACC  = 8,
    parameter int SZ_W     = 4,
    parameter int ADDR_W   = 3,
    parameter int KEY_W    = 16
) (
    input  logic                    write,
    input  logic                    ctl,
    input  logic [ADDR_W-1:0]       offset,
    input  logic [SZ_W-1:0]         size,
    input  logic [KEY_W-1:0]        wdata,
    output cfg_item_pkg::acc_kind_e kind,
    output logic [KEY_W-1:0]        key
);
    import cfg_item_pkg::*;
    localparam int KEY_BYTES = KEY_W / 8;

    if (COMBINED) begin : g_comb
        always_comb begin
            key = wdata;
            if (size == SZ_W'(1))                kind = write ? ACC_NOP : ACC_READ;
            else if (size == SZ_W'(2) && write)  kind = ACC_SEL;
            else                                 kind = ACC_ERR;
        end
    end else begin : g_split
        always_comb begin
            for (int b = 0; b < KEY_BYTES; b++) begin
                key[b*8 +: 8] = wdata[(KEY_BYTES-1-b)*8 +: 8];
            end
            if (ctl)                                          kind = (write && size == SZ_W'(2)) ? ACC_SEL : ACC_ERR;
            else if (offset != '0 || size == '0 || int'(size) > MAX_ACC) kind = ACC_ERR;
            else                                              kind = write ? ACC_NOP : ACC_READ;
        end
    end
endmodule

// File: rtl/cfg_item_pack.sv
module cfg_item_pack #(
    parameter int MAX_LEN = 8,
    parameter int MAX_ACC = 8,
    parameter int OFF_W   = 4,
    parameter int SZ_W    = 4
) (
    input  logic [MAX_LEN*8-1:0] item_bytes,
    input  logic [OFF_W-1:0]     item_len,
    input  logic [OFF_W-1:0]     off,
    input  logic                 sel_ok,
    input  logic [SZ_W-1:0]      size,
    output logic [MAX_ACC*8-1:0] rdata,
    output logic [OFF_W-1:0]     adv
);
    int avail;
    int take;

    always_comb begin
        rdata = '0;
        avail = (sel_ok && off < item_len) ? int'(item_len) - int'(off) : 0;
        take  = (int'(size) < avail) ? int'(size) : avail;
        for (int k = 0; k < MAX_ACC; k++) begin
            if (k < take) begin
                rdata[(int'(size) - 1 - k)*8 +: 8] = item_bytes[(int'(off) + k)*8 +: 8];
            end
        end
        adv = OFF_W'(take);
    end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port #(
    parameter int NUM_ENTRIES = 8,
    parameter int MAX_LEN     = 8,
    parameter int MAX_ACC     = 8,
    parameter int KEY_W       = 16,
    parameter int BANK_BIT    = 14,
    parameter bit COMBINED    = 1'b1,
    parameter bit DMA_AVAIL   = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic                         req_ctl,
    input  logic [$clog2(MAX_ACC)-1:0]   req_offset,
    input  logic [$clog2(MAX_ACC+1)-1:0] req_size,
    input  logic [KEY_W-1:0]             req_wdata,
    output logic                         rsp_valid,
    output logic                         rsp_err,
    output logic [MAX_ACC*8-1:0]         rsp_rdata
);
    import cfg_item_pkg::*;

    localparam int IDX_W  = $clog2(NUM_ENTRIES);
    localparam int OFF_W  = $clog2(MAX_LEN + 1);
    localparam int SZ_W   = $clog2(MAX_ACC + 1);
    localparam int ADDR_W = $clog2(MAX_ACC);
    localparam int DATA_W = MAX_ACC * 8;

    typedef struct packed {
        logic              sel_ok;
        logic              bank;
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  off;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
    } state_t;

    state_t s_d, s_q;

    acc_kind_e            kind;
    logic [KEY_W-1:0]     key;
    logic [MAX_LEN*8-1:0] item_bytes;
    logic [OFF_W-1:0]     item_len;
    logic [DATA_W-1:0]    pk_rdata;
    logic [OFF_W-1:0]     pk_adv;
    logic                 key_in_range;

    cfg_item_decode #(
        .COMBINED(COMBINED), .MAX_ACC(MAX_ACC), .SZ_W(SZ_W),
        .ADDR_W(ADDR_W), .KEY_W(KEY_W)
    ) u_decode (
        .write(req_write), .ctl(req_ctl), .offset(req_offset),
        .size(req_size), .wdata(req_wdata), .kind(kind), .key(key)
    );

    cfg_item_rom #(
        .NUM_ENTRIES(NUM_ENTRIES), .MAX_LEN(MAX_LEN), .IDX_W(IDX_W),
        .OFF_W(OFF_W), .DMA_AVAIL(DMA_AVAIL)
    ) u_rom (
        .bank(s_q.bank), .idx(s_q.idx), .item_bytes(item_bytes), .item_len(item_len)
    );

    cfg_item_pack #(
        .MAX_LEN(MAX_LEN), .MAX_ACC(MAX_ACC), .OFF_W(OFF_W), .SZ_W(SZ_W)
    ) u_pack (
        .item_bytes(item_bytes), .item_len(item_len), .off(s_q.off),
        .sel_ok(s_q.sel_ok), .size(req_size), .rdata(pk_rdata), .adv(pk_adv)
    );

    assign key_in_range = 32'(key[BANK_BIT-1:0]) < 32'(NUM_ENTRIES);

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = req_valid;
        s_d.rsp_err   = 1'b0;
        s_d.rsp_rdata = '0;
        if (req_valid) begin
            case (kind)
                ACC_SEL: begin
                    s_d.off    = '0;
                    s_d.sel_ok = key_in_range;
                    s_d.bank   = key[BANK_BIT];
                    s_d.idx    = key[IDX_W-1:0];
                end
                ACC_READ: begin
                    s_d.rsp_rdata = pk_rdata;
                    s_d.off       = s_q.off + pk_adv;
                end
                ACC_ERR:  s_d.rsp_err = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.sel_ok <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_err   = s_q.rsp_err;
    assign rsp_rdata = s_q.rsp_rdata;
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
    parameter int OFF_W  = 4,
    parameter int DATA_W = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input cfg_item_pkg::acc_kind_e kind,
    input logic                    sel_ok_q,
    input logic [OFF_W-1:0]        off_q,
    input logic [OFF_W-1:0]        item_len,
    input logic                    rsp_valid,
    input logic                    rsp_err,
    input logic [DATA_W-1:0]       rsp_rdata
);
    import cfg_item_pkg::*;

    p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_err_no_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> rsp_rdata == '0);
    p_sel_rewinds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_SEL) |=> off_q == '0);
    p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_READ && !sel_ok_q) |=> rsp_rdata == '0);
    p_refused_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_ERR) |=> ($stable(off_q) && $stable(sel_ok_q)));
    p_cursor_in_item_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ok_q |-> off_q <= item_len);
    p_cursor_forward_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == ACC_READ) |=> off_q >= $past(off_q));
endmodule

bind cfg_item_port cfg_item_port_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind),
    .sel_ok_q(s_q.sel_ok), .off_q(s_q.off), .item_len(item_len),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/cfg_item_port_bench.sv
module cfg_item_port_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        rq_v   [2];
    logic        rq_w   [2];
    logic        rq_c   [2];
    logic [2:0]  rq_o   [2];
    logic [3:0]  rq_s   [2];
    logic [15:0] rq_d   [2];
    logic        rs_v   [2];
    logic        rs_e   [2];
    logic [63:0] rs_d   [2];

    int errors = 0;
    int checks = 0;

    cfg_item_port #(.COMBINED(1'b1)) u_cfg_item_port (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_v[0]), .req_write(rq_w[0]),
        .req_ctl(rq_c[0]), .req_offset(rq_o[0]), .req_size(rq_s[0]),
        .req_wdata(rq_d[0]), .rsp_valid(rs_v[0]), .rsp_err(rs_e[0]),
        .rsp_rdata(rs_d[0])
    );

    cfg_item_port #(.COMBINED(1'b0)) u_cfg_item_port_split (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_v[1]), .req_write(rq_w[1]),
        .req_ctl(rq_c[1]), .req_offset(rq_o[1]), .req_size(rq_s[1]),
        .req_wdata(rq_d[1]), .rsp_valid(rs_v[1]), .rsp_err(rs_e[1]),
        .rsp_rdata(rs_d[1])
    );

    // Model state per layout (0 combined, 1 split)
    bit m_ok   [2];
    int m_bank [2];
    int m_idx  [2];
    int m_off  [2];

    function automatic int b_len(int bank, int idx);
        if (bank == 0 && idx < 2) return 4;
        return (idx + 2 + 2 * bank) % 9;
    endfunction

    function automatic logic [7:0] b_byte(int bank, int idx, int j);
        if (bank == 0 && idx == 0) begin
            case (j)
                0: return 8'h51;
                1: return 8'h45;
                2: return 8'h4D;
                default: return 8'h55;
            endcase
        end
        if (bank == 0 && idx == 1) return (j == 0) ? 8'h01 : 8'h00;
        return 8'((128 * bank + 16 * idx + j) % 256);
    endfunction

    task automatic check(string tag, logic [65:0] act, logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual {valid,err,data}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(int m, bit wr, bit ctl, int offs, int size, logic [15:0] wd,
                       output logic [65:0] resp);
        @(negedge clk);
        rq_v[m] = 1'b1; rq_w[m] = wr; rq_c[m] = ctl;
        rq_o[m] = 3'(offs); rq_s[m] = 4'(size); rq_d[m] = wd;
        @(negedge clk);
        resp = {rs_v[m], rs_e[m], rs_d[m]};
        rq_v[m] = 1'b0;
    endtask

    task automatic sel(int m, logic [15:0] key, string tag);
        logic [65:0] r;
        logic [15:0] wd;
        int idxf;
        wd = (m == 0) ? key : {key[7:0], key[15:8]};
        acc(m, 1'b1, 1'b1, 0, 2, wd, r);
        check(tag, r, {1'b1, 1'b0, 64'h0});
        idxf = int'(key[13:0]);
        m_off[m] = 0; m_ok[m] = idxf < 8; m_bank[m] = int'(key[14]); m_idx[m] = idxf;
    endtask

    task automatic rd(int m, int size, string tag);
        logic [65:0] r;
        logic [63:0] v;
        int len, avail, take;
        v = '0;
        if (m_ok[m]) begin
            len = b_len(m_bank[m], m_idx[m]);
            if (m_off[m] < len) begin
                avail = len - m_off[m];
                take = (size < avail) ? size : avail;
                for (int k = 0; k < take; k++)
                    v[(size-1-k)*8 +: 8] = b_byte(m_bank[m], m_idx[m], m_off[m] + k);
                m_off[m] += take;
            end
        end
        acc(m, 1'b0, 1'b0, 0, size, 16'h0, r);
        check(tag, r, {1'b1, 1'b0, v});
    endtask

    task automatic bad(int m, bit wr, bit ctl, int offs, int size, string tag);
        logic [65:0] r;
        acc(m, wr, ctl, offs, size, 16'($urandom), r);
        check(tag, r, {1'b1, 1'b1, 64'h0});
    endtask

    task automatic nopw(int m, int size, string tag);
        logic [65:0] r;
        acc(m, 1'b1, 1'b0, 0, size, 16'($urandom), r);
        check(tag, r, {1'b1, 1'b0, 64'h0});
    endtask

    function automatic logic [15:0] rand_key();
        logic [15:0] k;
        k = {2'(($urandom % 4)), 14'(($urandom % 11))};
        if ($urandom % 8 == 0) k[13:0] = 14'h3FFF;
        return k;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [65:0] r;
        void'($urandom(32'd4242));
        for (int m = 0; m < 2; m++) begin
            rq_v[m] = 0; rq_w[m] = 0; rq_c[m] = 0; rq_o[m] = 0; rq_s[m] = 0; rq_d[m] = 0;
            m_ok[m] = 1'b1; m_bank[m] = 0; m_idx[m] = 0; m_off[m] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset idle", {rs_v[0], rs_e[0], 64'h0}, 66'h0);
        check("R1 reset idle split", {rs_v[1], rs_e[1], 64'h0}, 66'h0);

        // R1/R8: signature byte by byte on combined, then past end (R7)
        for (int i = 0; i < 4; i++) rd(0, 1, "R1 R8 signature byte");
        rd(0, 1, "R7 read at end");
        rd(0, 1, "R7 cursor held at end");
        // R1/R6: 8-byte read of 4-byte signature on split
        rd(1, 8, "R1 R6 signature padded");
        // R10: version item, split big-endian key
        sel(1, 16'h0001, "R9 R10 select version");
        rd(1, 4, "R10 version word");
        // R3/R11: bank bit, bit 15 ignored
        sel(0, 16'h4003, "R3 select local 3");
        rd(0, 1, "R3 R11 local item byte");
        sel(1, 16'hC003, "R3 bit15 ignored");
        rd(1, 8, "R3 R6 R11 local item wide");
        sel(1, 16'h0002, "R3 shared 2");
        rd(1, 3, "R5 R11 shared partial");
        rd(1, 3, "R6 shared tail padded");
        rd(1, 2, "R7 exhausted");
        // R2: back-to-back read then reselect
        sel(1, 16'h0002, "R2 reselect");
        rd(1, 2, "R2 restarted at byte 0");
        // R4: invalid keys
        sel(0, 16'h0008, "R4 select index 8");
        rd(0, 1, "R4 invalid reads zero");
        sel(1, 16'h7FFF, "R4 select max index");
        rd(1, 8, "R4 invalid wide zero");
        // R7: empty items
        sel(1, 16'h4005, "R7 select empty local");
        rd(1, 8, "R7 empty reads zero");
        sel(0, 16'h0007, "R7 select empty shared");
        rd(0, 1, "R7 empty shared zero");
        // R8: combined refusals and ignored writes
        sel(0, 16'h0000, "R8 select signature");
        rd(0, 1, "R8 first byte");
        nopw(0, 1, "R8 byte write ignored");
        bad(0, 1'b0, 1'b0, 0, 2, "R8 2-byte read refused");
        bad(0, 1'b1, 1'b0, 0, 4, "R8 4-byte write refused");
        bad(0, 1'b0, 1'b1, 0, 8, "R8 8-byte read refused");
        rd(0, 1, "R8 cursor kept after refusals");
        // R9: split refusals and ignored writes
        sel(1, 16'h4002, "R9 select local 2");
        rd(1, 2, "R9 first pair");
        bad(1, 1'b1, 1'b1, 0, 1, "R9 ctl 1-byte refused");
        bad(1, 1'b0, 1'b1, 0, 2, "R9 ctl read refused");
        bad(1, 1'b0, 1'b0, 3, 1, "R9 data offset refused");
        bad(1, 1'b0, 1'b0, 0, 0, "R9 size 0 refused");
        bad(1, 1'b0, 1'b0, 0, 9, "R9 size 9 refused");
        nopw(1, 4, "R9 data write ignored");
        rd(1, 8, "R9 cursor kept");
        // R12: idle cycle after a response
        @(negedge clk);
        check("R12 response one cycle only", {rs_v[1], 65'h0}, 66'h0);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int m, op;
            m = int'($urandom % 2);
            op = int'($urandom % 10);
            if (op < 2) sel(m, rand_key(), "R2 R3 R4 random select");
            else if (op < 7) rd(m, (m == 0) ? 1 : 1 + int'($urandom % 8), "R5 R6 R7 random read");
            else if (op == 7) nopw(m, (m == 0) ? 1 : 1 + int'($urandom % 8), "R8 R9 random ignored write");
            else if (m == 0) begin
                if ($urandom % 2 == 0) bad(0, 1'b0, 1'b0, 0, 2, "R8 random refused");
                else bad(0, 1'($urandom), 1'b0, 0, 3 + int'($urandom % 6), "R8 random refused");
            end else begin
                if ($urandom % 2 == 0) bad(1, 1'b0, 1'b1, 0, 2, "R9 random refused");
                else bad(1, 1'($urandom), 1'b0, 1 + int'($urandom % 7), 1, "R9 random refused");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule